// File: doc/BRIEF.md
# Parallel Multi-Channel DShot Transmitter

The block drives a bank of ESC control lines in lockstep. A producer streams bytes across a valid/ready handshake. Each byte holds one frame bit position for every channel, and byte bit n belongs to line n. A 16-bit frame therefore takes sixteen bytes. The first byte carries frame bit 15, so every line sends its frame most-significant bit first. Building the frames (throttle, telemetry request, CRC) is done upstream.

Each bit period is split into three equal slots, each `SLOT_TICKS` ticks of `tick_i` long:
- In the first slot every line is high.
- In the middle slot each line shows its own data bit.
- In the last slot every line is low.

A zero bit is therefore high for one third of the period, and a one bit is high for two thirds. The `tick_i` enable divides the system clock. For example, it can be set so that 15 ticks span one DShot600 bit. When no byte is waiting at the end of a bit, the transmitter stalls with all lines low until the next byte arrives.

Top module: `dshot_par_tx`

## Requirements
- R1: A bit lasts exactly 3*SLOT_TICKS ticks (15 by default), counted from acceptance. When a byte is offered, the next bit starts on the clock after the final tick, with no gap.
- R2: In the clock after a byte is accepted, every line is driven high. The lines stay high until SLOT_TICKS ticks have been counted.
- R3: During the middle slot, line n equals bit n of the accepted byte. A 0 bit gives one high slot and a 1 bit gives two.
- R4: During the last slot, every line is low.
- R5: Sixteen consecutive bytes form one frame per channel. Byte k carries frame bit 15-k, and channel n receives bit n of each byte.
- R6: With no byte offered at the end of a bit, all lines stay low and no new bit begins.
- R7: `ready_o` is high only when the block is idle, or in the cycle of the last tick of the last slot. A byte is consumed only when `valid_i` and `ready_o` are both high.
- R8: During reset, all lines are low and the block is idle with `ready_o` high.
- R9: A clock cycle with `tick_i` low does not advance the slot timing, and the lines hold their level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slot-timing enable, one pulse per tick |
| valid_i | input | 1 | A bit byte is offered |
| data_i | input | N_CH | One frame bit for each channel, bit n for line n |
| ready_o | output | 1 | The byte is taken this cycle if valid_i is high |
| line_o | output | N_CH | ESC output lines |

## Verification
The end of one bit and the acceptance of the next byte can fall in the same cycle. In that cycle the final tick of the low slot raises `ready_o`, and the handshake completes at once. The bench provokes this by keeping the byte queue full under several tick patterns: every cycle, every third cycle, and a pseudo-random pattern. A behavioural tick-counting model checks each cycle that `ready_o` rises only with that final tick. It also checks that the lines go high in the very next clock, so the low slot is exactly SLOT_TICKS ticks long.

// File: rtl/dshot_par_pkg.sv
package dshot_par_pkg;
  typedef enum logic [1:0] {
    SLOT_HI   = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_LO   = 2'd2
  } slot_e;
endpackage

// File: rtl/dshot_slot_timer.sv
module dshot_slot_timer
  import dshot_par_pkg::*;
#(
  parameter int SLOT_TICKS = 5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  start_i,
  output slot_e slot_o,
  output logic  active_o,
  output logic  adv_o,
  output logic  bit_end_o
);
  localparam int CW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_TICKS - 1);

  logic [CW-1:0] cnt_q;
  slot_e         slot_q;
  logic          active_q;

  assign adv_o     = active_q & tick_i & (cnt_q == LAST);
  assign bit_end_o = adv_o & (slot_q == SLOT_LO);
  assign slot_o    = slot_q;
  assign active_o  = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      slot_q   <= SLOT_HI;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= '0;
      slot_q   <= SLOT_HI;
      active_q <= 1'b1;
    end else if (active_q && tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        unique case (slot_q)
          SLOT_HI:   slot_q <= SLOT_DATA;
          SLOT_DATA: slot_q <= SLOT_LO;
          default:   active_q <= 1'b0;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dshot_line_drv.sv
module dshot_line_drv
  import dshot_par_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [N_CH-1:0] data_i,
  input  logic            adv_i,
  input  slot_e           slot_i,
  output logic [N_CH-1:0] line_o
);
  logic [N_CH-1:0] hold_q;
  logic [N_CH-1:0] line_q;

  assign line_o = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      line_q <= '0;
    end else if (start_i) begin
      hold_q <= data_i;
      line_q <= '1;
    end else if (adv_i) begin
      // leaving a slot: show data after high slot, drop after data slot
      unique case (slot_i)
        SLOT_HI:   line_q <= hold_q;
        default:   line_q <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dshot_par_tx.sv
module dshot_par_tx
  import dshot_par_pkg::*;
#(
  parameter int N_CH       = 8,
  parameter int SLOT_TICKS = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            valid_i,
  input  logic [N_CH-1:0] data_i,
  output logic            ready_o,
  output logic [N_CH-1:0] line_o
);
  slot_e slot;
  logic  active, adv, bit_end, start;

  // byte taken only between bits
  assign ready_o = ~active | bit_end;
  assign start   = valid_i & ready_o;

  dshot_slot_timer #(.SLOT_TICKS(SLOT_TICKS)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .start_i  (start),
    .slot_o   (slot),
    .active_o (active),
    .adv_o    (adv),
    .bit_end_o(bit_end)
  );

  dshot_line_drv #(.N_CH(N_CH)) i_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .data_i (data_i),
    .adv_i  (adv),
    .slot_i (slot),
    .line_o (line_o)
  );
endmodule

// File: rtl/dshot_par_tx_chk.sv
module dshot_par_tx_chk #(
  parameter int N_CH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            valid_i,
  input logic [N_CH-1:0] data_i,
  input logic            ready_o,
  input logic [N_CH-1:0] line_o
);
  // R2
  accept_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (line_o == '1));

  // R6
  stall_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !valid_i) |=> (line_o == '0));

  // R9
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !(valid_i && ready_o)) |=> $stable(line_o));

  // R3
  no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && ready_o) |=> ((line_o & ~$past(line_o)) == '0));

  // R7
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !tick_i) |-> (line_o == '0));

  // R8
  always_comb begin
    if (!rst_ni) reset_low_chk: assert (line_o == '0);
  end
endmodule

bind dshot_par_tx dshot_par_tx_chk #(.N_CH(N_CH)) i_chk (.*);

// File: tb/test_dshot_par_tx.sv
module test_dshot_par_tx;
  localparam int N_CH = 8;
  localparam int ST   = 5;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            tick_i = 1'b0;
  logic            valid_i = 1'b0;
  logic [N_CH-1:0] data_i = '0;
  logic            ready_o;
  logic [N_CH-1:0] line_o;

  dshot_par_tx #(.N_CH(N_CH), .SLOT_TICKS(ST)) i_dshot_par_tx (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  logic [7:0]  tx_q[$];
  bit          busy = 0;
  int          cnt = 0;
  logic [N_CH-1:0] hold = '0, exp_line = '0, prev_line = '0;
  bit          exp_rdy;
  bit          samp_pend = 0;
  logic [15:0] rx [N_CH];
  logic [15:0] fr [N_CH];
  bit          done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic string line_tag();
    if (!busy) return "R6";
    if (cnt < ST) return "R2";
    if (cnt < 2*ST) return "R3";
    return "R4";
  endfunction

  // one clock: drive at negedge, compare, then step model at posedge
  task automatic step(input int tmode, input bit gaps);
    @(negedge clk_i);
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (tmode)
      0: tick_i = 1'b1;
      1: tick_i = (cyc % 3 == 0);
      default: tick_i = lfsr[0];
    endcase
    valid_i = (tx_q.size() > 0) && (!gaps || lfsr[3]);
    data_i  = (tx_q.size() > 0) ? tx_q[0] : '0;
    #1;
    exp_rdy = !busy || (cnt == 3*ST-1 && tick_i);
    chk(ready_o == exp_rdy, (busy && cnt == 3*ST-1) ? "R1" : "R7", ready_o, exp_rdy);
    chk(line_o == exp_line, line_tag(), line_o, exp_line);
    if (samp_pend) begin
      for (int c = 0; c < N_CH; c++) rx[c] = {rx[c][14:0], line_o[c]};
      samp_pend = 0;
    end
    @(posedge clk_i);
    prev_line = exp_line;
    if (valid_i && exp_rdy) begin
      busy = 1; cnt = 0; hold = data_i; exp_line = '1;
      void'(tx_q.pop_front());
    end else if (busy && tick_i) begin
      cnt++;
      if (cnt == ST) begin exp_line = hold; samp_pend = 1; end
      else if (cnt == 2*ST) exp_line = '0;
      else if (cnt == 3*ST) busy = 0;
    end
  endtask

  task automatic send_frame(input int seed, input int tmode, input bit gaps);
    logic [7:0] b;
    for (int c = 0; c < N_CH; c++) begin
      fr[c] = 16'hA5C3 ^ 16'(seed * 16'h1357) ^ 16'(c * 16'h0F11);
      rx[c] = '0;
    end
    for (int k = 0; k < 16; k++) begin
      for (int c = 0; c < N_CH; c++) b[c] = fr[c][15-k];
      tx_q.push_back(b);
    end
    while (tx_q.size() > 0 || busy) begin
      step(tmode, gaps);
      // R9: no tick, no new byte -> lines hold
      if (!tick_i && !(valid_i && exp_rdy))
        chk(line_o == prev_line, "R9", line_o, prev_line);
    end
    for (int c = 0; c < N_CH; c++)
      chk(rx[c] == fr[c], "R5", rx[c], fr[c]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R8
    chk(line_o == '0, "R8", line_o, 0);
    chk(ready_o == 1'b1, "R8", ready_o, 1);
    rst_ni = 1'b1;
    repeat (5) step(0, 0);
    send_frame(1, 0, 0);   // tick every clock, back-to-back bytes
    repeat (20) step(1, 0); // R6 stall, idle
    send_frame(2, 1, 0);   // sparse ticks
    send_frame(3, 2, 1);   // random ticks and gaps in valid
    send_frame(4, 2, 0);
    repeat (40) step(2, 0);
    chk(line_o == '0, "R6", line_o, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule